// File: doc/BRIEF.md
# In-Order Issue Stall Evaluator

This block sits at the head of an in-order issue queue and decides, every cycle, whether the oldest waiting instruction may issue. Hazard detection is done elsewhere: the block receives per-check hazard indications for the candidate (register dependency cycles, an unknown-latency flag, a structural busy flag, a memory alias flag and a custom stall count), together with the candidate's earliest write-back latency and a flag that allows it to retire out of order. When every check passes, it grants issue in the same cycle. When a check fails, it records a stall with a reason code and a count of remaining cycles.

A recorded stall blocks the queue head. It counts down at each clock edge. When the count reaches zero, the same instruction is evaluated again before anything else. Alongside the stall record, the block keeps a write-back horizon: the number of cycles until the most recent in-order instruction writes back. A younger in-order instruction that would write back sooner than that is held back, so results land in program order.

The environment keeps presenting the stalled instruction's hazard indications while it waits. The block evaluates them in the retry cycle.

Top module: `issue_stall_eval`

## Requirements
- R1: Checks are ranked from highest to lowest priority as register dependency, structural resource, memory alias, custom, write-back order. Only the highest-ranked failing check is recorded. The `stall_kind` codes are 0 none, 1 register, 2 resource, 3 memory, 4 custom, 5 write-back order. `stall_kind` is nonzero exactly while `stall_valid` is 1.
- R2: A register hazard with a nonzero `haz_reg_cycles` value N stalls for N cycles. When `haz_reg_unknown` is 1, the stall is one cycle whatever the count.
- R3: A structural resource hazard, or a memory alias, stalls for exactly one cycle.
- R4: A nonzero `haz_cust_cycles` value N stalls for N cycles. A value of zero means no custom hazard.
- R5: The write-back check applies only when the horizon H is nonzero and `cand_ooo_retire` is 0. If the candidate latency L is below H, the candidate stalls for H-L cycles. Otherwise it passes.
- R6: When an in-order candidate with nonzero latency L is granted, the horizon becomes L-1 after that clock edge, which is L counted from issue. At every other edge the horizon decrements while it is nonzero. Out-of-order-retire grants and zero-latency grants leave the horizon unloaded.
- R7: While a stall has nonzero cycles left, `issue_grant` stays 0. Any candidate or hazard presented in that time is ignored: the kind is held and the count keeps decrementing.
- R8: A stall of N cycles recorded in cycle t shows `stall_left` = N-k in cycle t+k. In cycle t+N, with `stall_left` = 0, the stalled instruction is re-evaluated without regard to `cand_valid`. If it passes, it is granted in that cycle.
- R9: After reset there is no stall, `stall_kind` is 0, `stall_left` is 0, no grant is given and the horizon is empty.
- R10: A valid candidate that passes every check while no stall is held gets `issue_grant` = 1 combinationally in the same cycle. `stall_valid` is 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cand_valid | input | 1 | A new candidate is at the queue head |
| haz_reg_cycles | input | CYC_W | Register dependency cycles remaining (0 = none) |
| haz_reg_unknown | input | 1 | Register dependency with unknown remaining cycles |
| haz_res_busy | input | 1 | Structural resource unavailable |
| haz_mem_alias | input | 1 | Memory ordering conflict with an older access |
| haz_cust_cycles | input | CYC_W | Custom stall cycles (0 = none) |
| cand_wb_lat | input | CYC_W | Candidate's earliest write-back latency |
| cand_ooo_retire | input | 1 | Candidate may retire out of order |
| issue_grant | output | 1 | Candidate issues this cycle |
| stall_valid | output | 1 | A stall is recorded |
| stall_kind | output | 3 | Stall reason code |
| stall_left | output | CYC_W | Cycles left before re-evaluation |

## Verification
A corrupted stall record shows at the ports immediately: `stall_kind`, `stall_left` and `stall_valid` are driven straight from the state, so a wrong count or reason is visible in the very next cycle. A wrong countdown also moves the grant to the wrong cycle, which the bench times exactly. A wrong write-back horizon is not visible by itself. It shows only when the next in-order candidate arrives, as a spurious stall, a missing stall or a delay of the wrong length. The bench therefore primes the horizon with every latency pair and idle gap, and times the resulting delay.

// File: rtl/issue_stall_pkg.sv
package issue_stall_pkg;

    typedef enum logic [2:0] {
        SK_NONE  = 3'd0,
        SK_REG   = 3'd1,
        SK_RES   = 3'd2,
        SK_MEM   = 3'd3,
        SK_CUST  = 3'd4,
        SK_WBORD = 3'd5
    } stall_kind_e;

    localparam int unsigned NUM_CHECKS = 5;

endpackage

// File: rtl/issue_stall_prio.sv
module issue_stall_prio
    import issue_stall_pkg::*;
#(
    parameter int unsigned CYC_W = 4
) (
    input  logic [CYC_W-1:0] reg_cycles,
    input  logic             reg_unknown,
    input  logic             res_busy,
    input  logic             mem_alias,
    input  logic [CYC_W-1:0] cust_cycles,
    input  logic [CYC_W-1:0] horizon,
    input  logic [CYC_W-1:0] cand_lat,
    input  logic             ooo_retire,
    output logic             hit,
    output stall_kind_e      kind,
    output logic [CYC_W-1:0] cycles
);

    localparam logic [CYC_W-1:0] ONE = CYC_W'(1);

    logic             fire [NUM_CHECKS];
    logic [CYC_W-1:0] dly  [NUM_CHECKS];
    stall_kind_e      code [NUM_CHECKS];

    // Index 0 is the highest priority.
    always_comb begin
        fire[0] = reg_unknown || (reg_cycles != '0);
        dly[0]  = reg_unknown ? ONE : reg_cycles;
        code[0] = SK_REG;

        fire[1] = res_busy;
        dly[1]  = ONE;
        code[1] = SK_RES;

        fire[2] = mem_alias;
        dly[2]  = ONE;
        code[2] = SK_MEM;

        fire[3] = (cust_cycles != '0);
        dly[3]  = cust_cycles;
        code[3] = SK_CUST;

        fire[4] = (horizon != '0) && !ooo_retire && (cand_lat < horizon);
        dly[4]  = horizon - cand_lat;
        code[4] = SK_WBORD;
    end

    always_comb begin
        hit    = 1'b0;
        kind   = SK_NONE;
        cycles = '0;
        for (int i = NUM_CHECKS - 1; i >= 0; i--) begin
            if (fire[i]) begin
                hit    = 1'b1;
                kind   = code[i];
                cycles = dly[i];
            end
        end
    end

endmodule

// File: rtl/issue_wb_horizon.sv
module issue_wb_horizon #(
    parameter int unsigned CYC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CYC_W-1:0] load_lat,
    output logic [CYC_W-1:0] horizon
);

    typedef struct packed {
        logic [CYC_W-1:0] cnt;
    } hz_t;

    hz_t hz_d, hz_q;

    always_comb begin
        hz_d = hz_q;
        if (load) begin
            hz_d.cnt = load_lat - CYC_W'(1);
        end else if (hz_q.cnt != '0) begin
            hz_d.cnt = hz_q.cnt - CYC_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hz_q <= '0;
        end else begin
            hz_q <= hz_d;
        end
    end

    assign horizon = hz_q.cnt;

endmodule

// File: rtl/issue_stall_eval.sv
module issue_stall_eval
    import issue_stall_pkg::*;
#(
    parameter int unsigned CYC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cand_valid,
    input  logic [CYC_W-1:0] haz_reg_cycles,
    input  logic             haz_reg_unknown,
    input  logic             haz_res_busy,
    input  logic             haz_mem_alias,
    input  logic [CYC_W-1:0] haz_cust_cycles,
    input  logic [CYC_W-1:0] cand_wb_lat,
    input  logic             cand_ooo_retire,
    output logic             issue_grant,
    output logic             stall_valid,
    output logic [2:0]       stall_kind,
    output logic [CYC_W-1:0] stall_left
);

    typedef struct packed {
        logic             valid;
        stall_kind_e      kind;
        logic [CYC_W-1:0] left;
    } stall_t;

    stall_t           st_d, st_q;
    logic             hit;
    stall_kind_e      hit_kind;
    logic [CYC_W-1:0] hit_cycles;
    logic [CYC_W-1:0] horizon;
    logic             busy;
    logic             retry;
    logic             eval;
    logic             grant;
    logic             wb_load;

    issue_stall_prio #(.CYC_W(CYC_W)) u_prio (
        .reg_cycles  (haz_reg_cycles),
        .reg_unknown (haz_reg_unknown),
        .res_busy    (haz_res_busy),
        .mem_alias   (haz_mem_alias),
        .cust_cycles (haz_cust_cycles),
        .horizon     (horizon),
        .cand_lat    (cand_wb_lat),
        .ooo_retire  (cand_ooo_retire),
        .hit         (hit),
        .kind        (hit_kind),
        .cycles      (hit_cycles)
    );

    issue_wb_horizon #(.CYC_W(CYC_W)) u_horizon (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wb_load),
        .load_lat (cand_wb_lat),
        .horizon  (horizon)
    );

    always_comb begin
        busy    = st_q.valid && (st_q.left != '0);
        retry   = st_q.valid && (st_q.left == '0);
        eval    = retry || (!st_q.valid && cand_valid);
        grant   = eval && !hit;
        wb_load = grant && !cand_ooo_retire && (cand_wb_lat != '0);

        st_d = st_q;
        if (busy) begin
            st_d.left = st_q.left - CYC_W'(1);
        end else if (eval) begin
            if (hit) begin
                st_d.valid = 1'b1;
                st_d.kind  = hit_kind;
                st_d.left  = hit_cycles - CYC_W'(1);
            end else begin
                st_d.valid = 1'b0;
                st_d.kind  = SK_NONE;
                st_d.left  = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{valid: 1'b0, kind: SK_NONE, left: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign issue_grant = grant;
    assign stall_valid = st_q.valid;
    assign stall_kind  = st_q.kind;
    assign stall_left  = st_q.left;

endmodule

// File: rtl/issue_stall_eval_chk.sv
module issue_stall_eval_chk #(
    parameter int unsigned CYC_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             eval,
    input logic [CYC_W-1:0] haz_reg_cycles,
    input logic             haz_reg_unknown,
    input logic             haz_res_busy,
    input logic             haz_mem_alias,
    input logic             issue_grant,
    input logic             stall_valid,
    input logic [2:0]       stall_kind,
    input logic [CYC_W-1:0] stall_left,
    input logic [CYC_W-1:0] horizon
);

    p_kind_matches_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
        stall_valid == (stall_kind != 3'd0));

    p_unknown_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        eval && haz_reg_unknown |=> stall_valid && stall_kind == 3'd1 && stall_left == '0);

    p_res_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        eval && !haz_reg_unknown && haz_reg_cycles == '0 && haz_res_busy
        |=> stall_valid && stall_kind == 3'd2 && stall_left == '0);

    p_mem_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        eval && !haz_reg_unknown && haz_reg_cycles == '0 && !haz_res_busy && haz_mem_alias
        |=> stall_valid && stall_kind == 3'd3 && stall_left == '0);

    p_horizon_dec_r6: assert property (@(posedge clk) disable iff (!rst_n)
        horizon != '0 && !issue_grant |=> horizon == $past(horizon) - CYC_W'(1));

    p_no_grant_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stall_valid && stall_left != '0 |-> !issue_grant);

    p_countdown_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stall_valid && stall_left != '0
        |=> stall_valid && $stable(stall_kind) && stall_left == $past(stall_left) - CYC_W'(1));

    p_retry_evaluates_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stall_valid && stall_left == '0 |-> eval);

    p_grant_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        issue_grant |=> !stall_valid);

endmodule

bind issue_stall_eval issue_stall_eval_chk #(.CYC_W(CYC_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .eval            (eval),
    .haz_reg_cycles  (haz_reg_cycles),
    .haz_reg_unknown (haz_reg_unknown),
    .haz_res_busy    (haz_res_busy),
    .haz_mem_alias   (haz_mem_alias),
    .issue_grant     (issue_grant),
    .stall_valid     (stall_valid),
    .stall_kind      (stall_kind),
    .stall_left      (stall_left),
    .horizon         (horizon)
);

// File: tb/issue_stall_eval_tb.sv
module issue_stall_eval_tb;

    localparam int CYC_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cand_valid = 1'b0;
    logic [CYC_W-1:0] haz_reg_cycles = '0;
    logic             haz_reg_unknown = 1'b0;
    logic             haz_res_busy = 1'b0;
    logic             haz_mem_alias = 1'b0;
    logic [CYC_W-1:0] haz_cust_cycles = '0;
    logic [CYC_W-1:0] cand_wb_lat = '0;
    logic             cand_ooo_retire = 1'b1;
    logic             issue_grant;
    logic             stall_valid;
    logic [2:0]       stall_kind;
    logic [CYC_W-1:0] stall_left;

    int n_vec = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    issue_stall_eval #(.CYC_W(CYC_W)) u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .cand_valid      (cand_valid),
        .haz_reg_cycles  (haz_reg_cycles),
        .haz_reg_unknown (haz_reg_unknown),
        .haz_res_busy    (haz_res_busy),
        .haz_mem_alias   (haz_mem_alias),
        .haz_cust_cycles (haz_cust_cycles),
        .cand_wb_lat     (cand_wb_lat),
        .cand_ooo_retire (cand_ooo_retire),
        .issue_grant     (issue_grant),
        .stall_valid     (stall_valid),
        .stall_kind      (stall_kind),
        .stall_left      (stall_left)
    );

    task automatic chk(input int act, input int exp, input string tag);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic drive(input logic v, input int rc, input logic unk, input logic res,
                         input logic mem, input int cust, input int lat, input logic ooo);
        cand_valid      = v;
        haz_reg_cycles  = CYC_W'(rc);
        haz_reg_unknown = unk;
        haz_res_busy    = res;
        haz_mem_alias   = mem;
        haz_cust_cycles = CYC_W'(cust);
        cand_wb_lat     = CYC_W'(lat);
        cand_ooo_retire = ooo;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        drive(0, 0, 0, 0, 0, 0, 0, 1);
        @(negedge clk);
        rst_n = 1'b1;
        #5;
        chk(stall_valid, 0, "R9 valid");
        chk(stall_kind, 0, "R9 kind");
        chk(stall_left, 0, "R9 left");
        chk(issue_grant, 0, "R9 grant");
    endtask

    // Present an in-order candidate that passes, loading the horizon with lat-1.
    task automatic prime(input int lat);
        @(negedge clk);
        drive(1, 0, 0, 0, 0, 0, lat, 0);
        #5;
        chk(issue_grant, 1, "R10 prime grant");
    endtask

    // Present a failing candidate, then time the stall and the retry grant.
    task automatic run_stall(input int rc, input logic unk, input logic res, input logic mem,
                             input int cust, input int lat, input logic ooo,
                             input int k, input int n, input string tag);
        @(negedge clk);
        drive(1, rc, unk, res, mem, cust, lat, ooo);
        #5;
        chk(issue_grant, 0, {tag, " no grant on hazard"});
        chk(stall_valid, 0, {tag, " idle before"});
        for (int j = 1; j <= n; j++) begin
            @(negedge clk);
            if (j < n) drive(1, 0, 0, 1, 0, 9, 0, 0);
            else       drive(1, 0, 0, 0, 0, 0, lat, ooo);
            #5;
            chk(stall_valid, 1, {tag, " R8 valid"});
            chk(stall_kind, k, {tag, " R7 kind held"});
            chk(stall_left, n - j, {tag, " R8 left"});
            chk(issue_grant, (j == n) ? 1 : 0, {tag, " R7 R8 grant timing"});
        end
        @(negedge clk);
        drive(0, 0, 0, 0, 0, 0, 0, 1);
        #5;
        chk(stall_valid, 0, {tag, " R10 cleared"});
        chk(issue_grant, 0, {tag, " no grant when idle"});
    endtask

    initial begin
        #(200000 * 20);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        do_reset();

        // R10: clean candidate grants combinationally; no candidate, no grant
        @(negedge clk);
        drive(1, 0, 0, 0, 0, 0, 0, 1);
        #5;
        chk(issue_grant, 1, "R10 clean grant");
        @(negedge clk);
        drive(0, 0, 0, 0, 0, 0, 0, 1);
        #5;
        chk(stall_valid, 0, "R10 no stall after grant");
        chk(issue_grant, 0, "R10 idle no grant");

        // R2: register hazard counts
        for (int n = 1; n < 16; n++) begin
            do_reset();
            run_stall(n, 0, 0, 0, 0, 0, 1, 1, n, "R2 reg");
        end
        // R2: unknown latency is one cycle
        do_reset();
        run_stall(0, 1, 0, 0, 0, 0, 1, 1, 1, "R2 unknown");
        do_reset();
        run_stall(7, 1, 0, 0, 0, 0, 1, 1, 1, "R2 unknown with count");

        // R3: resource and memory alias
        do_reset();
        run_stall(0, 0, 1, 0, 0, 0, 1, 2, 1, "R3 resource");
        do_reset();
        run_stall(0, 0, 0, 1, 0, 0, 1, 3, 1, "R3 memory");

        // R4: custom counts
        for (int n = 1; n < 16; n++) begin
            do_reset();
            run_stall(0, 0, 0, 0, n, 0, 1, 4, n, "R4 custom");
        end

        // R5: write-back ordering, horizon L-1 against latency M
        for (int l = 2; l < 16; l++) begin
            for (int m = 0; m < l - 1; m++) begin
                do_reset();
                prime(l);
                run_stall(0, 0, 0, 0, 0, m, 0, 5, l - 1 - m, "R5 wb order");
            end
        end
        // R5: equal or later write-back passes
        do_reset();
        prime(5);
        @(negedge clk);
        drive(1, 0, 0, 0, 0, 0, 4, 0);
        #5;
        chk(issue_grant, 1, "R5 equal latency passes");
        // R5: out-of-order retire bypasses the check
        do_reset();
        prime(9);
        @(negedge clk);
        drive(1, 0, 0, 0, 0, 0, 0, 1);
        #5;
        chk(issue_grant, 1, "R5 ooo bypass");

        // R6: horizon decrements through idle cycles
        for (int g = 0; g < 8; g++) begin
            do_reset();
            prime(9);
            for (int i = 0; i < g; i++) begin
                @(negedge clk);
                drive(0, 0, 0, 0, 0, 0, 0, 1);
            end
            if (8 - g > 2) begin
                run_stall(0, 0, 0, 0, 0, 2, 0, 5, 6 - g, "R6 decrement");
            end else begin
                @(negedge clk);
                drive(1, 0, 0, 0, 0, 0, 2, 0);
                #5;
                chk(issue_grant, 1, "R6 decrement expired");
            end
        end
        // R6: out-of-order grant leaves the horizon unloaded
        do_reset();
        @(negedge clk);
        drive(1, 0, 0, 0, 0, 0, 10, 1);
        #5;
        chk(issue_grant, 1, "R6 ooo grant");
        @(negedge clk);
        drive(1, 0, 0, 0, 0, 0, 0, 0);
        #5;
        chk(issue_grant, 1, "R6 ooo no load");
        // R6: zero-latency grant leaves the horizon unloaded
        do_reset();
        prime(0);
        @(negedge clk);
        drive(1, 0, 0, 0, 0, 0, 3, 0);
        #5;
        chk(issue_grant, 1, "R6 zero latency no load");

        // R1: priority over all 32 combinations of the five checks
        for (int c = 0; c < 32; c++) begin
            int ek;
            int en;
            do_reset();
            if (c[4]) prime(15);
            ek = 0;
            en = 0;
            if (c[4]) begin ek = 5; en = 14; end
            if (c[3]) begin ek = 4; en = 5; end
            if (c[2]) begin ek = 3; en = 1; end
            if (c[1]) begin ek = 2; en = 1; end
            if (c[0]) begin ek = 1; en = 3; end
            @(negedge clk);
            drive(1, c[0] ? 3 : 0, 0, c[1], c[2], c[3] ? 5 : 0, 0, !c[4]);
            #5;
            chk(issue_grant, (c == 0) ? 1 : 0, "R1 grant");
            @(negedge clk);
            drive(0, 0, 0, 0, 0, 0, 0, 1);
            #5;
            chk(stall_valid, (c == 0) ? 0 : 1, "R1 valid");
            chk(stall_kind, ek, "R1 kind");
            chk(stall_left, (en == 0) ? 0 : en - 1, "R1 left");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule